// File: doc/BRIEF.md
# Pipelined Hamming-Distance Threshold Filter

This block compares two binary vectors and decides whether they are close enough to count as a match. On each valid input it XORs the two vectors and counts the ones in the result, which gives their Hamming distance. The block then reports that distance together with a match flag. The count comes from a tree: a first row of 6-input counting cells that have no carry chain, followed by rows of pairwise adders. Optional registers between rows let the block accept one vector pair on every clock.

A per-pair mode input selects how the distance is judged. In threshold mode it is compared with a threshold input. In vector mode it is compared with the ones count of a third reference vector, which a second, identical tree counts in parallel. The mode and the threshold travel through the pipeline with their own pair, so they may change from one cycle to the next. With the default 64-bit width and a threshold of 3, the block works as a near-duplicate detector.

Top module: `hd_threshold_filter`

## Requirements
- R1: When out_valid is high, out_count equals the number of bit positions in which vec_a and vec_b differed, for the pair that produced the result.
- R2: With mode = 0 (threshold mode), out_match is 1 exactly when out_count is less than or equal to the threshold sampled with that pair.
- R3: With mode = 1 (vector mode), out_match is 1 exactly when out_count is less than or equal to the number of ones in the vec_ref sampled with that pair.
- R4: A pair presented with in_valid high produces out_valid high exactly LATENCY cycles later. LATENCY is 7 for the defaults (WIDTH = 64, PIPELINE = 1). Pairs presented on consecutive cycles produce results on consecutive cycles.
- R5: mode and threshold are captured together with each pair. A change between two back-to-back pairs affects only the later pair.
- R6: A synchronous active-high rst clears every valid stage. out_valid is 0 in the cycle after a reset edge, and pairs that were in flight at that edge never come out.
- R7: Bits past WIDTH in the last 6-bit group count as zero. With WIDTH = 64, which is not a multiple of 6, all-ones against all-zeros gives out_count = 64.
- R8: out_count and threshold are ceil(log2(WIDTH+1)) bits wide, which is 7 bits for WIDTH = 64.
- R9: Cycles with in_valid low produce no result. out_valid stays 0 in the matching output cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid stages |
| in_valid | input | 1 | Qualifies the input pair and its controls |
| vec_a | input | WIDTH | First vector |
| vec_b | input | WIDTH | Second vector |
| vec_ref | input | WIDTH | Reference vector, counted in vector mode |
| mode | input | 1 | 0 = compare with threshold, 1 = compare with vec_ref count |
| threshold | input | CW | Largest distance that still matches in threshold mode |
| out_valid | output | 1 | Result qualifier |
| out_count | output | CW | Hamming distance of the pair |
| out_match | output | 1 | Result of the selected comparison |

## Verification
The bench targets distances that sit exactly on the threshold and one either side of it. A strict less-than compare would drop the equal case. It also sends all-ones against all-zeros: a padding bit taken as one would push the count above 64, and an undersized adder would wrap it. Mode and threshold switch on every cycle of a back-to-back burst, so any control that was not carried with its own pair would judge that pair with the next pair's setting. Bubbles and a reset in the middle of the stream check that in-flight results are neither duplicated nor able to survive the reset.

// File: rtl/hd_pkg.sv
package hd_pkg;
   localparam int CELL_IN = 6;

   typedef enum logic {
      MODE_THRESH = 1'b0,
      MODE_VECTOR = 1'b1
   } hd_mode_e;

   function automatic int group_count(input int width);
      return (width + CELL_IN - 1) / CELL_IN;
   endfunction

   function automatic int tree_levels(input int leaves);
      int l;
      l = 0;
      while ((1 << l) < leaves) l++;
      return l;
   endfunction
endpackage

// File: rtl/hd_count6.sv
module hd_count6 (
   input  logic [5:0] bits_i,
   output logic [2:0] ones_o
);
   // Flat 6-in/3-out function: maps onto one lookup level, no ripple.
   always_comb begin
      ones_o = 3'd0;
      for (int i = 0; i < 6; i++) ones_o = ones_o + {2'b00, bits_i[i]};
   end
endmodule

// File: rtl/hd_pop_tree.sv
module hd_pop_tree #(
   parameter int WIDTH    = 64,
   parameter bit PIPELINE = 1'b1,
   localparam int CW      = $clog2(WIDTH + 1)
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] vec_i,
   output logic [CW-1:0]    count_o
);
   localparam int G    = hd_pkg::group_count(WIDTH);
   localparam int PADW = G * hd_pkg::CELL_IN;
   localparam int ADD  = hd_pkg::tree_levels(G);
   localparam int P    = 1 << ADD;

   logic [PADW-1:0]           padded;
   logic [2:0]                cell_ones [G];
   logic [2*P-1:1][CW-1:0]    node_d;
   logic [2*P-1:1][CW-1:0]    node_q;

   assign padded = PADW'(vec_i);

   // Heap layout: node n sums children 2n and 2n+1; leaves sit at P..2P-1.
   for (genvar n = 1; n < 2 * P; n++) begin : g_node
      if (n >= P) begin : g_leaf
         if (n - P < G) begin : g_cell
            hd_count6 u_cell (
               .bits_i (padded[(n-P)*hd_pkg::CELL_IN +: hd_pkg::CELL_IN]),
               .ones_o (cell_ones[n-P])
            );
            assign node_d[n] = CW'(cell_ones[n-P]);
         end else begin : g_empty
            assign node_d[n] = '0;
         end
      end else begin : g_add
         assign node_d[n] = node_q[2*n] + node_q[2*n+1];
      end
   end

   if (PIPELINE) begin : g_reg
      always_ff @(posedge clk) node_q <= node_d;
   end else begin : g_comb
      assign node_q = node_d;
   end

   assign count_o = node_q[1];
endmodule

// File: rtl/hd_delay.sv
module hd_delay #(
   parameter int DEPTH = 1,
   parameter int W     = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] d_o
);
   if (DEPTH == 0) begin : g_wire
      assign d_o = d_i;
   end else begin : g_shift
      logic [DEPTH-1:0][W-1:0] stage_q;
      always_ff @(posedge clk) begin
         if (rst) stage_q <= '0;
         else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
         end
      end
      assign d_o = stage_q[DEPTH-1];
   end
endmodule

// File: rtl/hd_threshold_filter.sv
module hd_threshold_filter #(
   parameter int WIDTH    = 64,
   parameter bit PIPELINE = 1'b1,
   localparam int CW      = $clog2(WIDTH + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [WIDTH-1:0] vec_a,
   input  logic [WIDTH-1:0] vec_b,
   input  logic [WIDTH-1:0] vec_ref,
   input  logic             mode,
   input  logic [CW-1:0]    threshold,
   output logic             out_valid,
   output logic [CW-1:0]    out_count,
   output logic             out_match
);
   localparam int G       = hd_pkg::group_count(WIDTH);
   localparam int ADD     = hd_pkg::tree_levels(G);
   localparam int TREE_L  = PIPELINE ? ADD + 1 : 0;
   localparam int LATENCY = TREE_L + 2;
   localparam int IW      = $clog2(LATENCY + 2);

   if (WIDTH < hd_pkg::CELL_IN) begin : g_bad_width
      $error("hd_threshold_filter: WIDTH must be at least 6");
   end

   // Capture stage
   logic             v0_q;
   logic [WIDTH-1:0] diff0_q, ref0_q;
   logic             mode0_q;
   logic [CW-1:0]    thr0_q;

   always_ff @(posedge clk) begin
      if (rst) v0_q <= 1'b0;
      else     v0_q <= in_valid;
      diff0_q <= vec_a ^ vec_b;
      ref0_q  <= vec_ref;
      mode0_q <= mode;
      thr0_q  <= threshold;
   end

   // Counting trees and matched-latency side paths
   logic [CW-1:0] dist_c, refc_c;
   logic          v_t;
   logic [CW:0]   side_t;

   hd_pop_tree #(.WIDTH(WIDTH), .PIPELINE(PIPELINE)) u_dist (
      .clk (clk), .vec_i (diff0_q), .count_o (dist_c));
   hd_pop_tree #(.WIDTH(WIDTH), .PIPELINE(PIPELINE)) u_ref (
      .clk (clk), .vec_i (ref0_q), .count_o (refc_c));

   hd_delay #(.DEPTH(TREE_L), .W(1)) u_vdly (
      .clk (clk), .rst (rst), .d_i (v0_q), .d_o (v_t));
   hd_delay #(.DEPTH(TREE_L), .W(CW + 1)) u_sdly (
      .clk (clk), .rst (rst), .d_i ({mode0_q, thr0_q}), .d_o (side_t));

   // Judge stage
   logic [CW-1:0] limit_c;
   assign limit_c = (hd_pkg::hd_mode_e'(side_t[CW]) == hd_pkg::MODE_VECTOR)
                    ? refc_c : side_t[CW-1:0];

   always_ff @(posedge clk) begin
      if (rst) out_valid <= 1'b0;
      else     out_valid <= v_t;
      out_count <= dist_c;
      out_match <= (dist_c <= limit_c);
   end

   // Checks
   logic [IW-1:0] inflight_q;
   always_ff @(posedge clk) begin
      if (rst) inflight_q <= '0;
      else     inflight_q <= inflight_q + IW'(in_valid) - IW'(out_valid);
   end

   AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_count <= CW'(WIDTH)));                        // R1
   AST_ZERO_MATCHES: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_count == '0) |-> out_match);                   // R2
   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> !out_valid);                                             // R6
   AST_RESULT_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (inflight_q != '0));                               // R4
   AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (rst)
      inflight_q <= IW'(LATENCY));                                     // R4
endmodule

// File: tb/hd_threshold_filter_bench.sv
module hd_threshold_filter_bench;
   localparam int CLK_PERIOD = 10;
   localparam int W   = 64;
   localparam int CW  = 7;
   localparam int LAT = 7;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic [W-1:0]  vec_a = '0, vec_b = '0, vec_ref = '0;
   logic          mode = 1'b0;
   logic [CW-1:0] threshold = '0;
   logic          out_valid;
   logic [CW-1:0] out_count;
   logic          out_match;

   hd_threshold_filter u_hd_threshold_filter (
      .clk (clk), .rst (rst), .in_valid (in_valid),
      .vec_a (vec_a), .vec_b (vec_b), .vec_ref (vec_ref),
      .mode (mode), .threshold (threshold),
      .out_valid (out_valid), .out_count (out_count), .out_match (out_match));

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      int    due;
      int    cnt;
      bit    m;
      string tag;
   } exp_t;

   exp_t  q[$];
   int    cyc = 0;
   int    tests = 0;
   int    fails = 0;
   bit    last_rst = 1'b1;
   string phase_tag = "";
   bit    done = 1'b0;

   always @(posedge clk) cyc++;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
      end
   endtask

   task automatic tick(input bit r, input bit v, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic [W-1:0] rf,
                       input bit md, input int th);
      exp_t e;
      @(negedge clk);
      if (q.size() > 0 && q[0].due == cyc) begin
         chk(out_valid == 1'b1, "R4", out_valid, 1);
         if (out_valid) begin
            chk(out_count == q[0].cnt, "R1", out_count, q[0].cnt);
            chk(out_match == q[0].m, q[0].tag, out_match, q[0].m);
         end
         void'(q.pop_front());
      end else begin
         chk(out_valid == 1'b0, last_rst ? "R6" : "R9", out_valid, 0);
      end
      rst       = r;
      in_valid  = v;
      vec_a     = a;
      vec_b     = b;
      vec_ref   = rf;
      mode      = md;
      threshold = CW'(th);
      last_rst  = r;
      if (r) q.delete();
      else if (v) begin
         e.due = cyc + LAT;
         e.cnt = $countones(a ^ b);
         if (md) e.m = (e.cnt <= $countones(rf));
         else    e.m = (e.cnt <= th);
         e.tag = (phase_tag != "") ? phase_tag : (md ? "R3" : "R2");
         q.push_back(e);
      end
   endtask

   function automatic logic [W-1:0] flip(input logic [W-1:0] a, input int k);
      logic [W-1:0] r;
      r = a;
      for (int i = 0; i < k; i++) r[$urandom_range(W-1)] ^= 1'b1;
      return r;
   endfunction

   function automatic logic [W-1:0] rnd();
      return {$urandom(), $urandom()};
   endfunction

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick(1'b0, 1'b0, '0, '0, '0, 1'b0, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      fails++;
      tests++;
      $display("FAIL watchdog expired, actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [W-1:0] a;
      // R8: result and threshold widths
      chk($bits(out_count) == CW, "R8", $bits(out_count), CW);
      chk($bits(threshold) == CW, "R8", $bits(threshold), CW);
      for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, '0, '0, '0, 1'b0, 0);
      idle(LAT + 2);                       // R6: reset state

      // R2: threshold boundary, distance 3/4/2 against threshold 3
      a = rnd();
      tick(1'b0, 1'b1, a, a ^ 64'h7, '0, 1'b0, 3);
      tick(1'b0, 1'b1, a, a ^ 64'hF, '0, 1'b0, 3);
      tick(1'b0, 1'b1, a, a ^ 64'h3, '0, 1'b0, 3);
      tick(1'b0, 1'b1, a, a, '0, 1'b0, 0);
      // R7: padding of last group, full distance
      tick(1'b0, 1'b1, '1, '0, '0, 1'b0, 63);
      tick(1'b0, 1'b1, '1, '0, '0, 1'b0, 64);
      // R3: vector mode boundary
      tick(1'b0, 1'b1, a, a ^ 64'hFF, 64'hFF, 1'b1, 0);
      tick(1'b0, 1'b1, a, a ^ 64'h1FF, 64'hFF, 1'b1, 0);
      tick(1'b0, 1'b1, '1, '0, '1, 1'b1, 0);
      idle(LAT + 1);

      // R5: mode and threshold change on every back-to-back pair
      phase_tag = "R5";
      for (int i = 0; i < 20; i++) begin
         a = rnd();
         tick(1'b0, 1'b1, a, flip(a, i % 6), flip('0, 3), i[0], i % 5);
      end
      phase_tag = "";
      idle(LAT + 1);

      // R9: bubbles between random pairs of mixed modes
      for (int i = 0; i < 60; i++) begin
         a = rnd();
         tick(1'b0, $urandom_range(1), a,
              ($urandom_range(3) == 0) ? rnd() : flip(a, $urandom_range(8)),
              rnd(), $urandom_range(1), $urandom_range(40));
      end

      // R6: reset with a full pipeline, then results must be lost
      for (int i = 0; i < LAT; i++) begin
         a = rnd();
         tick(1'b0, 1'b1, a, flip(a, 2), '0, 1'b0, 3);
      end
      tick(1'b1, 1'b1, '1, '0, '0, 1'b0, 3);
      idle(LAT + 2);

      // R4: long back-to-back stream after reset
      for (int i = 0; i < 30; i++) begin
         a = rnd();
         tick(1'b0, 1'b1, a, flip(a, i % 10), rnd(), i[1], 5);
      end
      idle(LAT + 2);
      chk(q.size() == 0, "R4", q.size(), 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule